// File: doc/BRIEF.md
# Interrupt Routing Configuration Register Block

This block is the register front end of an interrupt routing service. Software reaches it over a plain 32-bit register bus: a byte address, a write strobe, write data, and read data that follows the address combinationally. Read-only identification words report the implemented shared-interrupt window (its first ID and its size), the total number of shared interrupts in the system, the priority field width and the affinity-ID width. A control word holds a global enable next to a read-only idle flag. An attribute word stores the memory-attribute hints that software programs for table accesses.

Per-interrupt trigger mode and per-element enables are reached indirectly. Software writes a select word, polls a status word until it reads idle, checks the valid flag, writes the configure word, and polls idle again. Each accepted select, configure or element-control write keeps the unit busy for a parameterised number of cycles. A configure or control write that arrives while the unit is busy, or while the current selection is not valid, has no effect on the stored state.

Top module: `irq_route_regs`

## Requirements
- R1: After reset every register reads zero except the idle flags: control word (0x080) reads 0x2, and both status words (0x118, 0x144) read 0x1.
- R2: Offset 0x004 reports the priority-width code (0..4 for 1..5 bits) in bits 22:20 and the affinity-ID width minus one in bits 19:16. Offset 0x014 reports the global interrupt count in bits 24:0, 0x018 the local window size in bits 24:0, and 0x01C the window base in bits 23:0. All other bits read zero.
- R3: Control word 0x080: bit 0 is a read/write global enable. Bit 1 is read-only and reads 1 only while both indirect units are idle. Writes to bit 1 have no effect.
- R4: Attribute word 0x084 stores write-data bits 15:0 and reads them back. Bits 31:16 read zero.
- R5: After an accepted select, configure or element-control write, the idle flag of that unit (status bit 0) reads 0 for exactly BUSY_CYCLES clock cycles and then returns to 1.
- R6: Interrupt select 0x108 stores an ID in bits 23:0 and reads it back. Status bit 1 at 0x118 reads 1 only when that ID lies within base to base+size-1.
- R7: A write to interrupt configure 0x114 while idle with a valid selection stores bit 0 (1 = level, 0 = edge) for the selected ID. Reading 0x114 returns the stored mode of the selected ID, or 0 if the selection is invalid.
- R8: A configure write while the interrupt unit is busy changes no trigger mode and does not restart the busy window.
- R9: A configure write under an invalid selection changes no trigger mode of any ID.
- R10: Element select 0x140 stores a 16-bit affinity ID. Status bit 1 at 0x144 is 1 only when the ID is below 2^AFF_W and below PE_COUNT.
- R11: Element control 0x148 bit 0 stores the enable of the selected element when the unit is idle and the selection is valid. Otherwise the write is ignored. Reads return the enable of the selected element, or 0 if the selection is invalid.
- R12: Offsets that are not mapped read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
A corrupted busy counter shows on the status idle bit within the same cycle. An idle flag that returns one cycle early or late, or a window that restarts on an ignored write, moves the first cycle in which idle reads 1. A mode or enable bit stored at the wrong index, or stored under an invalid or busy condition, stays hidden until software reselects the affected ID and reads the configure or control word. The bench therefore reselects neighbouring and aliased IDs after each discarded write. A wrong valid computation is visible on the status word as soon as the busy window of the select write ends.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [11:0] OFS_IDENT  = 12'h004;
  localparam logic [11:0] OFS_GCOUNT = 12'h014;
  localparam logic [11:0] OFS_LRANGE = 12'h018;
  localparam logic [11:0] OFS_LBASE  = 12'h01C;
  localparam logic [11:0] OFS_CTRL   = 12'h080;
  localparam logic [11:0] OFS_ATTR   = 12'h084;
  localparam logic [11:0] OFS_ISEL   = 12'h108;
  localparam logic [11:0] OFS_ICFG   = 12'h114;
  localparam logic [11:0] OFS_ISTAT  = 12'h118;
  localparam logic [11:0] OFS_ESEL   = 12'h140;
  localparam logic [11:0] OFS_ESTAT  = 12'h144;
  localparam logic [11:0] OFS_ECTL   = 12'h148;

  typedef enum logic [3:0] {
    RS_NONE, RS_IDENT, RS_GCOUNT, RS_LRANGE, RS_LBASE, RS_CTRL, RS_ATTR,
    RS_ISEL, RS_ICFG, RS_ISTAT, RS_ESEL, RS_ESTAT, RS_ECTL
  } reg_sel_e;

  typedef struct packed {
    logic valid;
    logic idle;
  } unit_status_t;

  function automatic reg_sel_e decode_offset(input logic [11:0] ofs);
    unique case (ofs)
      OFS_IDENT:  decode_offset = RS_IDENT;
      OFS_GCOUNT: decode_offset = RS_GCOUNT;
      OFS_LRANGE: decode_offset = RS_LRANGE;
      OFS_LBASE:  decode_offset = RS_LBASE;
      OFS_CTRL:   decode_offset = RS_CTRL;
      OFS_ATTR:   decode_offset = RS_ATTR;
      OFS_ISEL:   decode_offset = RS_ISEL;
      OFS_ICFG:   decode_offset = RS_ICFG;
      OFS_ISTAT:  decode_offset = RS_ISTAT;
      OFS_ESEL:   decode_offset = RS_ESEL;
      OFS_ESTAT:  decode_offset = RS_ESTAT;
      OFS_ECTL:   decode_offset = RS_ECTL;
      default:    decode_offset = RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_route_busy.sv
module irq_route_busy #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle
);
  localparam int unsigned CW = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign idle = (cnt_q == '0);

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !idle); // R5
  AST_IDLE_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start) |=> idle); // R5

endmodule

// File: rtl/irq_route_icfg.sv
module irq_route_icfg #(
  parameter int unsigned WIN_BASE    = 64,
  parameter int unsigned WIN_SIZE    = 32,
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_we,
  input  logic        cfg_we,
  input  logic [23:0] wr_id,
  input  logic        wr_mode,
  output logic [23:0] sel_id,
  output irq_route_pkg::unit_status_t status,
  output logic        cfg_mode
);
  localparam int unsigned IW = (WIN_SIZE > 1) ? $clog2(WIN_SIZE) : 1;
  localparam logic [31:0] LO = 32'(WIN_BASE);
  localparam logic [31:0] HI = 32'(WIN_BASE) + 32'(WIN_SIZE);

  logic [23:0]         sel_q;
  logic                valid_q, valid_d;
  logic [WIN_SIZE-1:0] mode_q;
  logic                idle;
  logic                start;
  logic                cfg_ok;
  logic [IW-1:0]       idx;

  assign start  = sel_we | (cfg_we & idle);
  assign cfg_ok = cfg_we & idle & valid_q;
  assign idx    = IW'(sel_q - 24'(WIN_BASE));

  always_comb begin
    valid_d = ({8'd0, wr_id} >= LO) && ({8'd0, wr_id} < HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      valid_q <= 1'b0;
    end else if (sel_we) begin
      sel_q   <= wr_id;
      valid_q <= valid_d;
    end
  end

  for (genvar g = 0; g < WIN_SIZE; g++) begin : g_mode
    logic hit;
    assign hit = cfg_ok && (idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mode_q[g] <= 1'b0;
      else if (hit) mode_q[g] <= wr_mode;
    end
  end

  irq_route_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .idle  (idle)
  );

  assign sel_id       = sel_q;
  assign status.idle  = idle;
  assign status.valid = valid_q;
  assign cfg_mode     = valid_q & mode_q[idx];

  AST_CFG_BUSY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !idle) |=> $stable(mode_q)); // R8
  AST_CFG_INVALID_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !valid_q) |=> $stable(mode_q)); // R9

endmodule

// File: rtl/irq_route_ecfg.sv
module irq_route_ecfg #(
  parameter int unsigned AFF_W       = 4,
  parameter int unsigned PE_COUNT    = 12,
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_we,
  input  logic        ctl_we,
  input  logic [15:0] wr_aff,
  input  logic        wr_en,
  output logic [15:0] sel_aff,
  output irq_route_pkg::unit_status_t status,
  output logic        ctl_en
);
  localparam int unsigned PW = (PE_COUNT > 1) ? $clog2(PE_COUNT) : 1;
  localparam logic [31:0] WIDTH_LIM = 32'd1 << AFF_W;
  localparam logic [31:0] COUNT_LIM = 32'(PE_COUNT);

  logic [15:0]         sel_q;
  logic                valid_q, valid_d;
  logic [PE_COUNT-1:0] en_q;
  logic                idle;
  logic                start;
  logic                ctl_ok;
  logic [PW-1:0]       idx;

  assign start  = sel_we | (ctl_we & idle);
  assign ctl_ok = ctl_we & idle & valid_q;
  assign idx    = PW'(sel_q);

  always_comb begin
    valid_d = ({16'd0, wr_aff} < WIDTH_LIM) && ({16'd0, wr_aff} < COUNT_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      valid_q <= 1'b0;
    end else if (sel_we) begin
      sel_q   <= wr_aff;
      valid_q <= valid_d;
    end
  end

  for (genvar g = 0; g < PE_COUNT; g++) begin : g_en
    logic hit;
    assign hit = ctl_ok && (idx == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   en_q[g] <= 1'b0;
      else if (hit) en_q[g] <= wr_en;
    end
  end

  irq_route_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .idle  (idle)
  );

  assign sel_aff      = sel_q;
  assign status.idle  = idle;
  assign status.valid = valid_q;
  assign ctl_en       = valid_q & en_q[idx];

  AST_CTL_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !(idle && valid_q)) |=> $stable(en_q)); // R11

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned WIN_BASE     = 64,
  parameter int unsigned WIN_SIZE     = 32,
  parameter int unsigned GLOBAL_COUNT = 96,
  parameter int unsigned PRIO_CODE    = 4,
  parameter int unsigned AFF_W        = 4,
  parameter int unsigned PE_COUNT     = 12,
  parameter int unsigned BUSY_CYCLES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  import irq_route_pkg::*;

  localparam logic [2:0]  PRIO_F  = 3'(PRIO_CODE);
  localparam logic [3:0]  AFF_F   = 4'(AFF_W - 1);
  localparam logic [31:0] IDENT_V = {9'd0, PRIO_F, AFF_F, 16'd0};
  localparam logic [31:0] GCNT_V  = {7'd0, 25'(GLOBAL_COUNT)};
  localparam logic [31:0] LRNG_V  = {7'd0, 25'(WIN_SIZE)};
  localparam logic [31:0] LBASE_V = {8'd0, 24'(WIN_BASE)};

  reg_sel_e     rsel;
  logic         ctrl_we, attr_we, isel_we, icfg_we, esel_we, ectl_we;
  logic         en_q, en_d;
  logic [15:0]  attr_q, attr_d;
  logic [23:0]  isel;
  logic [15:0]  esel;
  logic         imode, eenable, all_idle;
  unit_status_t ists, ests;
  logic [7:0]   unused_wdata_hi;

  assign unused_wdata_hi = bus_wdata[31:24];
  assign rsel = decode_offset(12'(bus_addr));

  always_comb begin
    ctrl_we = bus_we && (rsel == RS_CTRL);
    attr_we = bus_we && (rsel == RS_ATTR);
    isel_we = bus_we && (rsel == RS_ISEL);
    icfg_we = bus_we && (rsel == RS_ICFG);
    esel_we = bus_we && (rsel == RS_ESEL);
    ectl_we = bus_we && (rsel == RS_ECTL);
  end

  always_comb begin
    en_d   = bus_wdata[0];
    attr_d = bus_wdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (ctrl_we) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       attr_q <= '0;
    else if (attr_we) attr_q <= attr_d;
  end

  irq_route_icfg #(
    .WIN_BASE    (WIN_BASE),
    .WIN_SIZE    (WIN_SIZE),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_icfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (isel_we),
    .cfg_we   (icfg_we),
    .wr_id    (bus_wdata[23:0]),
    .wr_mode  (bus_wdata[0]),
    .sel_id   (isel),
    .status   (ists),
    .cfg_mode (imode)
  );

  irq_route_ecfg #(
    .AFF_W       (AFF_W),
    .PE_COUNT    (PE_COUNT),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_ecfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_we  (esel_we),
    .ctl_we  (ectl_we),
    .wr_aff  (bus_wdata[15:0]),
    .wr_en   (bus_wdata[0]),
    .sel_aff (esel),
    .status  (ests),
    .ctl_en  (eenable)
  );

  assign all_idle = ists.idle & ests.idle;

  always_comb begin
    bus_rdata = '0;
    unique case (rsel)
      RS_IDENT:  bus_rdata = IDENT_V;
      RS_GCOUNT: bus_rdata = GCNT_V;
      RS_LRANGE: bus_rdata = LRNG_V;
      RS_LBASE:  bus_rdata = LBASE_V;
      RS_CTRL:   bus_rdata = {30'd0, all_idle, en_q};
      RS_ATTR:   bus_rdata = {16'd0, attr_q};
      RS_ISEL:   bus_rdata = {8'd0, isel};
      RS_ICFG:   bus_rdata = {31'd0, imode};
      RS_ISTAT:  bus_rdata = {30'd0, ists.valid, ists.idle};
      RS_ESEL:   bus_rdata = {16'd0, esel};
      RS_ESTAT:  bus_rdata = {30'd0, ests.valid, ests.idle};
      RS_ECTL:   bus_rdata = {31'd0, eenable};
      default:   bus_rdata = '0;
    endcase
  end

  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(en_q)); // R3
  AST_ATTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !attr_we |=> $stable(attr_q)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == RS_NONE) |-> (bus_rdata == 32'd0)); // R12

endmodule

// File: tb/irq_route_regs_tb.sv
`timescale 1ns/1ps
module irq_route_regs_tb;
  localparam int BUSY = 4;

  typedef struct packed {
    logic        wr;
    logic [11:0] waddr;
    logic [31:0] wdata;
    logic [11:0] raddr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0,        12'h004, 32'h00430000, 8'd2},  // R2
    '{1'b0, 12'h000, 32'h0,        12'h014, 32'd96,       8'd2},  // R2
    '{1'b0, 12'h000, 32'h0,        12'h018, 32'd32,       8'd2},  // R2
    '{1'b0, 12'h000, 32'h0,        12'h01C, 32'h40,       8'd2},  // R2
    '{1'b1, 12'h084, 32'hFFFFFFFF, 12'h084, 32'h0000FFFF, 8'd4},  // R4
    '{1'b1, 12'h080, 32'h1,        12'h080, 32'h3,        8'd3},  // R3
    '{1'b1, 12'h108, 32'hAB000045, 12'h118, 32'h3,        8'd6},  // R6
    '{1'b1, 12'h114, 32'h1,        12'h114, 32'h1,        8'd7},  // R7
    '{1'b1, 12'h108, 32'h5F,       12'h118, 32'h3,        8'd6},  // R6
    '{1'b1, 12'h108, 32'h60,       12'h118, 32'h1,        8'd6},  // R6
    '{1'b1, 12'h108, 32'h3F,       12'h108, 32'h3F,       8'd6},  // R6
    '{1'b1, 12'h140, 32'd11,       12'h144, 32'h3,        8'd10}, // R10
    '{1'b1, 12'h148, 32'h1,        12'h148, 32'h1,        8'd11}, // R11
    '{1'b1, 12'h140, 32'd12,       12'h144, 32'h1,        8'd10}, // R10
    '{1'b1, 12'h140, 32'h10,       12'h144, 32'h1,        8'd10}, // R10
    '{1'b1, 12'h200, 32'hFFFF,     12'h200, 32'h0,        8'd12}  // R12
  };

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  int          n_checks;
  int          n_errors;

  irq_route_regs u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    bus_we   = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic settle();
    repeat (BUSY) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    n_checks  = 0;
    n_errors  = 0;
    rst_n     = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h080, d); chk("R1 ctrl", d, 32'h2);
    rd(12'h118, d); chk("R1 irq status", d, 32'h1);
    rd(12'h144, d); chk("R1 pe status", d, 32'h1);
    rd(12'h084, d); chk("R1 attr", d, 32'h0);
    rd(12'h108, d); chk("R1 irq select", d, 32'h0);
    rd(12'h114, d); chk("R1 irq cfg", d, 32'h0);
    rd(12'h148, d); chk("R1 pe ctl", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        wr(VECS[i].waddr, VECS[i].wdata);
        settle();
      end
      rd(VECS[i].raddr, d);
      n_checks++;
      if (d !== VECS[i].exp) begin
        n_errors++;
        $display("FAIL R%0d vector %0d got=0x%08h exp=0x%08h",
                 VECS[i].req, i, d, VECS[i].exp);
      end
    end

    // R5 busy window length
    wr(12'h108, 32'h45);
    rd(12'h118, d); chk("R5 busy right after select", d, 32'h2);
    repeat (BUSY - 1) @(negedge clk);
    rd(12'h118, d); chk("R5 still busy last cycle", d, 32'h2);
    @(negedge clk);
    rd(12'h118, d); chk("R5 idle after window", d, 32'h3);

    // R8 configure while busy: dropped, no restart
    wr(12'h108, 32'h45);
    wr(12'h114, 32'h0);
    repeat (BUSY - 2) @(negedge clk);
    rd(12'h118, d); chk("R8 window not restarted (busy)", d, 32'h2);
    @(negedge clk);
    rd(12'h118, d); chk("R8 window not restarted (idle)", d, 32'h3);
    rd(12'h114, d); chk("R8 mode kept", d, 32'h1);

    // R7 edge mode written
    wr(12'h114, 32'h0); settle();
    rd(12'h114, d); chk("R7 edge mode", d, 32'h0);
    wr(12'h114, 32'h1); settle();

    // R9 invalid selection
    wr(12'h108, 32'h60); settle();
    wr(12'h114, 32'h1); settle();
    rd(12'h114, d); chk("R7 invalid selection reads 0", d, 32'h0);
    wr(12'h108, 32'h40); settle();
    rd(12'h114, d); chk("R9 no alias write", d, 32'h0);
    wr(12'h108, 32'h45); settle();
    rd(12'h114, d); chk("R9 other id intact", d, 32'h1);

    // R11 control while busy / invalid
    wr(12'h140, 32'd11);
    wr(12'h148, 32'h0);
    settle();
    rd(12'h148, d); chk("R11 busy write ignored", d, 32'h1);
    wr(12'h140, 32'd12); settle();
    wr(12'h148, 32'h1); settle();
    rd(12'h148, d); chk("R11 invalid reads 0", d, 32'h0);
    wr(12'h140, 32'd0); settle();
    rd(12'h148, d); chk("R11 element 0 untouched", d, 32'h0);
    wr(12'h140, 32'd11); settle();
    rd(12'h148, d); chk("R11 element 11 kept", d, 32'h1);

    // R3 global idle and read-only bit
    wr(12'h140, 32'd3);
    rd(12'h080, d); chk("R3 idle low while element unit busy", d, 32'h1);
    settle();
    wr(12'h080, 32'h2); settle();
    rd(12'h080, d); chk("R3 enable cleared, idle not writable", d, 32'h2);

    // R12 unmapped write has no side effect
    wr(12'h088, 32'hFFFF); settle();
    rd(12'h084, d); chk("R12 attr unaffected", d, 32'hFFFF);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule